// File: doc/BRIEF.md
# Matrix Scan Key Event Tracker

This block sits behind a keyboard matrix scanner. Each finished scan hands it a list of up to eight scancodes. The block decides whether the scan can be trusted. It can shift the keys onto a second layer while a function key is held. It then turns the difference between this scan and the last accepted one into a stream of key events.

A scancode packs a row and a column of the matrix. When three pressed keys form the corner pattern that makes a phantom fourth key appear, the optional ghost filter throws the whole scan away. For an accepted scan, the block first emits a release for every previously held key that has gone. It then emits a press for every key in the new set, and the new set becomes the held set. Events leave one at a time over a valid/ready pair. A one-cycle strobe marks the end of every scan's processing, including a discarded one.

Top module: `ket_tracker`

## Requirements
- R1: A scancode is 7 bits: bits [2:0] are the column and bits [6:3] are the row. Slot i of `scan_codes` sits at bits [7i+6:7i] and is used only when i < `scan_cnt`.
- R2: The ghost check runs only when `ghost_en` is 1 and at least 3 keys remain after the function key is removed. Otherwise the scan is always accepted.
- R3: A scan is ghosted when some key has a later key in its row and also a later key in its column. A ghosted scan emits no events, pulses `scan_done`, and leaves the held set unchanged.
- R4: With `fn_en` at 1 and the function scancode present in the scan, the function key is not reported and every other code gets 128 added (`ev_code[7]`=1). With `fn_en` at 0 the function scancode is reported like any other key, and no shift is applied.
- R5: For each held key missing from the new set, a release (`ev_press`=0) is emitted, in held order. All releases come before any press.
- R6: Every accepted scan emits a press (`ev_press`=1) for each of its keys, in input order. The new set then becomes the held set.
- R7: A scan with zero keys releases every held key and empties the held set.
- R8: An event transfers when `ev_valid` and `ev_ready` are both 1. While `ev_ready` is 0, `ev_code` and `ev_press` hold steady.
- R9: `scan_done` pulses for one cycle after the last event of each scan. No event is offered during that cycle.
- R10: `scan_ready` is 1 only when the block is idle, never while events are pending. After reset, `scan_ready`=1, `ev_valid`=0, `scan_done`=0, and the held set is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ghost_en | input | 1 | Enables the ghost filter |
| fn_en | input | 1 | Enables the function layer |
| scan_valid | input | 1 | A scan list is offered |
| scan_ready | output | 1 | Block is idle and takes a scan |
| scan_cnt | input | 4 | Number of used slots |
| scan_codes | input | 56 | Eight 7-bit scancodes, slot 0 lowest |
| ev_valid | output | 1 | An event is offered |
| ev_ready | input | 1 | Event sink accepts |
| ev_code | output | 8 | Event code, bit 7 = function layer |
| ev_press | output | 1 | 1 = press, 0 = release |
| scan_done | output | 1 | End-of-scan strobe |

## Verification
The bench keeps eight slots, a 4-bit row and a 3-bit column. It overrides the function scancode to 58 (row 7, column 2), so the function key collides in row and column with ordinary test keys. With eight slots, a full scan fills every position of the compaction and of the held-set search. A scan whose ghost pivot is not the first key shows that the per-key rule decides the outcome. Ready stalls that repeat every third cycle exercise the hold rule in both the release phase and the press phase.

// File: rtl/ket_pkg.sv
package ket_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REL,
    ST_PRS,
    ST_FIN
  } ket_state_e;

  // row index of a packed scancode
  function automatic int row_of(int code, int col_w);
    return code >> col_w;
  endfunction

  // column index of a packed scancode
  function automatic int col_of(int code, int col_w);
    return code & ((1 << col_w) - 1);
  endfunction

  // move a scancode onto the function layer (one full key space up)
  function automatic int layer_shift(int code, bit on, int sc_w);
    return on ? code + (1 << sc_w) : code;
  endfunction

endpackage

// File: rtl/ket_prep.sv
module ket_prep #(
  parameter int SLOTS   = 8,
  parameter int SC_W    = 7,
  parameter int CNT_W   = 4,
  parameter int FN_CODE = 127
) (
  input  logic [SLOTS*SC_W-1:0] raw_codes,
  input  logic [CNT_W-1:0]      raw_cnt,
  input  logic                  fn_en,
  output logic [SLOTS*SC_W-1:0] kept_codes,
  output logic [CNT_W-1:0]      kept_cnt,
  output logic                  fn_hit
);

  logic [SC_W-1:0]  cd;
  logic [CNT_W-1:0] pos;

  // drop the function key when the layer is on, compact the rest in order
  always_comb begin
    kept_codes = '0;
    pos        = '0;
    fn_hit     = 1'b0;
    cd         = '0;
    for (int i = 0; i < SLOTS; i++) begin
      cd = raw_codes[i*SC_W +: SC_W];
      if (i < int'(raw_cnt)) begin
        if (fn_en && (cd == SC_W'(FN_CODE))) begin
          fn_hit = 1'b1;
        end else begin
          kept_codes[int'(pos)*SC_W +: SC_W] = cd;
          pos = pos + 1'b1;
        end
      end
    end
    kept_cnt = pos;
  end

endmodule

// File: rtl/ket_ghost.sv
module ket_ghost #(
  parameter int SLOTS = 8,
  parameter int SC_W  = 7,
  parameter int COL_W = 3,
  parameter int CNT_W = 4
) (
  input  logic [SLOTS*SC_W-1:0] codes,
  input  logic [CNT_W-1:0]      cnt,
  input  logic                  en,
  output logic                  ghost
);

  logic [SLOTS-1:0] pivot_hit;

  // one pivot per slot: needs a later key in its row and a later key in its column
  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_pivot
    logic row_seen, col_seen;
    int   ci, cj;
    always_comb begin
      row_seen = 1'b0;
      col_seen = 1'b0;
      ci = int'(codes[gi*SC_W +: SC_W]);
      cj = 0;
      for (int j = gi + 1; j < SLOTS; j++) begin
        cj = int'(codes[j*SC_W +: SC_W]);
        if (j < int'(cnt)) begin
          if (ket_pkg::row_of(cj, COL_W) == ket_pkg::row_of(ci, COL_W)) row_seen = 1'b1;
          if (ket_pkg::col_of(cj, COL_W) == ket_pkg::col_of(ci, COL_W)) col_seen = 1'b1;
        end
      end
      pivot_hit[gi] = (gi < int'(cnt)) && row_seen && col_seen;
    end
  end

  assign ghost = en && (int'(cnt) >= 3) && (|pivot_hit);

endmodule

// File: rtl/ket_emit.sv
module ket_emit #(
  parameter int SLOTS = 8,
  parameter int EV_W  = 8,
  parameter int CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scan_valid,
  output logic                  scan_ready,
  input  logic [SLOTS*EV_W-1:0] new_codes,
  input  logic [CNT_W-1:0]      new_cnt,
  input  logic                  ghost,
  output logic                  ev_valid,
  input  logic                  ev_ready,
  output logic [EV_W-1:0]       ev_code,
  output logic                  ev_press,
  output logic                  scan_done
);
  import ket_pkg::*;

  ket_state_e            state_q;
  logic [SLOTS*EV_W-1:0] held_q, new_q;
  logic [CNT_W-1:0]      held_cnt_q, new_cnt_q, idx_q, idx_sel;
  logic                  ghost_q;

  logic            scan_take, ev_take, rel_end, prs_end, still_held;
  logic [EV_W-1:0] cur_held, cur_new;

  assign scan_take = scan_valid && scan_ready;
  assign ev_take   = ev_valid && ev_ready;
  assign idx_sel   = (int'(idx_q) < SLOTS) ? idx_q : '0;
  assign cur_held  = held_q[int'(idx_sel)*EV_W +: EV_W];
  assign cur_new   = new_q[int'(idx_sel)*EV_W +: EV_W];
  assign rel_end   = (state_q == ST_REL) && (idx_q == held_cnt_q);
  assign prs_end   = (state_q == ST_PRS) && (idx_q == new_cnt_q);

  // is the held key under the release cursor also in the new set
  always_comb begin
    still_held = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      if ((k < int'(new_cnt_q)) && (new_q[k*EV_W +: EV_W] == cur_held)) still_held = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      held_q     <= '0;
      new_q      <= '0;
      held_cnt_q <= '0;
      new_cnt_q  <= '0;
      idx_q      <= '0;
      ghost_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (scan_take) begin
            new_q     <= new_codes;
            new_cnt_q <= new_cnt;
            ghost_q   <= ghost;
            idx_q     <= '0;
            state_q   <= ghost ? ST_FIN : ST_REL;
          end
        end
        ST_REL: begin
          if (rel_end) begin
            idx_q   <= '0;
            state_q <= ST_PRS;
          end else if (still_held || ev_take) begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_PRS: begin
          if (prs_end) state_q <= ST_FIN;
          else if (ev_take) idx_q <= idx_q + 1'b1;
        end
        ST_FIN: begin
          if (!ghost_q) begin
            held_q     <= new_q;
            held_cnt_q <= new_cnt_q;
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scan_ready = (state_q == ST_IDLE);
  assign ev_valid   = ((state_q == ST_REL) && !rel_end && !still_held) ||
                      ((state_q == ST_PRS) && !prs_end);
  assign ev_code    = (state_q == ST_REL) ? cur_held : cur_new;
  assign ev_press   = (state_q == ST_PRS);
  assign scan_done  = (state_q == ST_FIN);

  // R8
  ev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_code) && $stable(ev_press));

  // R5
  rel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take && ev_press |=> !(ev_valid && !ev_press));

  // R3
  ghost_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_take && ghost |=> scan_done && !ev_valid);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> scan_ready && !ev_valid);

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> !scan_ready);

  // R7
  empty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done && !ghost_q && (new_cnt_q == '0) |=> (held_cnt_q == '0));

endmodule

// File: rtl/ket_tracker.sv
module ket_tracker #(
  parameter int SLOTS   = 8,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 3,
  parameter int FN_CODE = 127
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   ghost_en,
  input  logic                                   fn_en,
  input  logic                                   scan_valid,
  output logic                                   scan_ready,
  input  logic [$clog2(SLOTS+1)-1:0]             scan_cnt,
  input  logic [SLOTS*(ROW_W+COL_W)-1:0]         scan_codes,
  output logic                                   ev_valid,
  input  logic                                   ev_ready,
  output logic [ROW_W+COL_W:0]                   ev_code,
  output logic                                   ev_press,
  output logic                                   scan_done
);

  localparam int SC_W  = ROW_W + COL_W;
  localparam int EV_W  = SC_W + 1;
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [SLOTS*SC_W-1:0] kept_codes;
  logic [SLOTS*EV_W-1:0] lay_codes;
  logic [CNT_W-1:0]      kept_cnt;
  logic                  fn_hit, ghost;

  ket_prep #(.SLOTS(SLOTS), .SC_W(SC_W), .CNT_W(CNT_W), .FN_CODE(FN_CODE)) u_prep (
    .raw_codes (scan_codes),
    .raw_cnt   (scan_cnt),
    .fn_en     (fn_en),
    .kept_codes(kept_codes),
    .kept_cnt  (kept_cnt),
    .fn_hit    (fn_hit)
  );

  ket_ghost #(.SLOTS(SLOTS), .SC_W(SC_W), .COL_W(COL_W), .CNT_W(CNT_W)) u_ghost (
    .codes(kept_codes),
    .cnt  (kept_cnt),
    .en   (ghost_en),
    .ghost(ghost)
  );

  for (genvar k = 0; k < SLOTS; k++) begin : g_layer
    assign lay_codes[k*EV_W +: EV_W] =
      EV_W'(ket_pkg::layer_shift(int'(kept_codes[k*SC_W +: SC_W]), fn_hit, SC_W));
  end

  ket_emit #(.SLOTS(SLOTS), .EV_W(EV_W), .CNT_W(CNT_W)) u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_valid(scan_valid),
    .scan_ready(scan_ready),
    .new_codes (lay_codes),
    .new_cnt   (kept_cnt),
    .ghost     (ghost),
    .ev_valid  (ev_valid),
    .ev_ready  (ev_ready),
    .ev_code   (ev_code),
    .ev_press  (ev_press),
    .scan_done (scan_done)
  );

endmodule

// File: tb/sim_ket_tracker.sv
module sim_ket_tracker;

  localparam int FN = 58;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ghost_en = 1'b0, fn_en = 1'b0;
  logic        scan_valid = 1'b0, ev_ready = 1'b1;
  logic [3:0]  scan_cnt = '0;
  logic [55:0] scan_codes = '0;
  logic        scan_ready, ev_valid, ev_press, scan_done;
  logic [7:0]  ev_code;

  int total = 0, bad = 0;
  int sc[8];
  int sc_n;
  int held_m[8];
  int held_n = 0;
  int exp_code[16], exp_press[16], exp_n;
  int got_code[16], got_press[16], got_n;

  always #2 clk = ~clk;

  ket_tracker #(.SLOTS(8), .ROW_W(4), .COL_W(3), .FN_CODE(FN)) u0 (
    .clk(clk), .rst_n(rst_n), .ghost_en(ghost_en), .fn_en(fn_en),
    .scan_valid(scan_valid), .scan_ready(scan_ready), .scan_cnt(scan_cnt),
    .scan_codes(scan_codes), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_code(ev_code), .ev_press(ev_press), .scan_done(scan_done)
  );

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  task automatic set_keys(int n, int k0 = 0, int k1 = 0, int k2 = 0, int k3 = 0,
                          int k4 = 0, int k5 = 0, int k6 = 0, int k7 = 0);
    sc_n = n;
    sc[0] = k0; sc[1] = k1; sc[2] = k2; sc[3] = k3;
    sc[4] = k4; sc[5] = k5; sc[6] = k6; sc[7] = k7;
  endtask

  // independent model: builds the expected event list and updates the held set
  task automatic model();
    int kept[8];
    int nl[8];
    int kn = 0;
    bit fnh = 0, gh = 0;
    for (int i = 0; i < sc_n; i++) begin
      if (fn_en && sc[i] == FN) fnh = 1;
      else begin kept[kn] = sc[i]; kn++; end
    end
    if (ghost_en && kn >= 3) begin
      for (int i = 0; i < kn; i++) begin
        bit r = 0, c = 0;
        for (int j = i + 1; j < kn; j++) begin
          if (kept[j] / 8 == kept[i] / 8) r = 1;
          if (kept[j] % 8 == kept[i] % 8) c = 1;
        end
        if (r && c) gh = 1;
      end
    end
    for (int k = 0; k < kn; k++) nl[k] = kept[k] + (fnh ? 128 : 0);
    exp_n = 0;
    if (!gh) begin
      for (int h = 0; h < held_n; h++) begin
        bit found = 0;
        for (int k = 0; k < kn; k++) if (nl[k] == held_m[h]) found = 1;
        if (!found) begin exp_code[exp_n] = held_m[h]; exp_press[exp_n] = 0; exp_n++; end
      end
      for (int k = 0; k < kn; k++) begin
        exp_code[exp_n] = nl[k]; exp_press[exp_n] = 1; exp_n++;
      end
      for (int k = 0; k < kn; k++) held_m[k] = nl[k];
      held_n = kn;
    end
  endtask

  task automatic do_scan(string tag, bit stall);
    bit done_seen = 0, prev_stall = 0;
    int prev_code = 0, guard = 0;
    model();
    for (int i = 0; i < 8; i++) scan_codes[i*7 +: 7] = 7'(sc[i]);
    scan_cnt = 4'(sc_n);
    while (!scan_ready) @(negedge clk);
    scan_valid = 1'b1;
    @(negedge clk);
    scan_valid = 1'b0;
    chk(!scan_ready, {tag, " R10 busy after accept"}, int'(scan_ready), 0);
    got_n = 0;
    while (!done_seen && guard < 200) begin
      ev_ready = stall ? (guard % 3 != 0) : 1'b1;
      if (prev_stall)
        chk(ev_valid && int'(ev_code) == prev_code, {tag, " R8 hold while stalled"},
            int'(ev_code), prev_code);
      if (ev_valid && ev_ready && got_n < 16) begin
        got_code[got_n] = int'(ev_code); got_press[got_n] = int'(ev_press); got_n++;
      end
      prev_stall = ev_valid && !ev_ready;
      prev_code  = int'(ev_code);
      if (scan_done) begin
        done_seen = 1;
        chk(!ev_valid, {tag, " R9 no event with done"}, int'(ev_valid), 0);
      end
      guard++;
      @(negedge clk);
    end
    ev_ready = 1'b1;
    chk(done_seen, {tag, " R9 done strobe"}, int'(done_seen), 1);
    chk(!scan_done && scan_ready, {tag, " R9 single-cycle done"}, int'(scan_done), 0);
    chk(got_n == exp_n, {tag, " event count"}, got_n, exp_n);
    for (int e = 0; e < exp_n && e < got_n; e++) begin
      chk(got_code[e] == exp_code[e], {tag, " code"}, got_code[e], exp_code[e]);
      chk(got_press[e] == exp_press[e], {tag, " press flag"}, got_press[e], exp_press[e]);
    end
  endtask

  task automatic t_reset();
    chk(scan_ready == 1'b1, "R10 reset scan_ready", int'(scan_ready), 1);
    chk(ev_valid == 1'b0, "R10 reset ev_valid", int'(ev_valid), 0);
    chk(scan_done == 1'b0, "R10 reset scan_done", int'(scan_done), 0);
  endtask

  task automatic t_basic();
    ghost_en = 0; fn_en = 0;
    set_keys(1, 12);          do_scan("R6 single press", 0);
    set_keys(2, 12, 20);      do_scan("R6 add key", 0);
    set_keys(1, 20);          do_scan("R5 drop first", 0);
    set_keys(3, 9, 20, 33);   do_scan("R6 input order", 0);
    set_keys(2, 44, 9);       do_scan("R5 release order", 0);
  endtask

  task automatic t_empty();
    set_keys(3, 3, 9, 17);    do_scan("R7 setup", 0);
    set_keys(0);              do_scan("R7 empty scan", 0);
    set_keys(0);              do_scan("R7 empty twice", 0);
  endtask

  task automatic t_ghost();
    ghost_en = 1; fn_en = 0;
    set_keys(1, 20);          do_scan("R3 setup", 0);
    set_keys(3, 0, 1, 8);     do_scan("R3 ghost dropped", 0);
    set_keys(0);              do_scan("R3 held kept after ghost", 0);
    set_keys(2, 0, 1);        do_scan("R2 two keys pass", 0);
    set_keys(3, 0, 9, 18);    do_scan("R2 three keys no pattern", 0);
    set_keys(3, 1, 0, 8);     do_scan("R3 per-pivot rule accepts", 0);
    ghost_en = 0;
    set_keys(3, 0, 1, 8);     do_scan("R2 filter off", 0);
    set_keys(0);              do_scan("R2 clear", 0);
  endtask

  task automatic t_fn();
    ghost_en = 0; fn_en = 1;
    set_keys(3, FN, 4, 17);   do_scan("R4 layer shift", 0);
    set_keys(1, 4);           do_scan("R4 layer released", 0);
    fn_en = 0;
    set_keys(2, FN, 4);       do_scan("R4 fn off reported", 0);
    fn_en = 1; ghost_en = 1;
    set_keys(3, FN, 56, 57);  do_scan("R4 R2 fn removed before ghost", 0);
    set_keys(4, 0, FN, 1, 8); do_scan("R4 R3 ghost after removal", 0);
    ghost_en = 0; fn_en = 0;
    set_keys(0);              do_scan("R4 clear", 0);
  endtask

  task automatic t_stall();
    set_keys(3, 5, 6, 7);     do_scan("R8 stalled presses", 1);
    set_keys(1, 40);          do_scan("R8 stalled releases", 1);
  endtask

  task automatic t_full();
    set_keys(8, 0, 9, 18, 27, 36, 45, 54, 63); do_scan("R1 eight slots", 0);
    set_keys(8, 0, 9, 18, 27, 36, 45, 54, 63); scan_codes = '0;
    set_keys(4, 120, 9, 127, 63);              do_scan("R1 partial count", 0);
    set_keys(0);                               do_scan("R1 clear", 0);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL R9 watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_empty();
    t_ghost();
    t_fn();
    t_stall();
    t_full();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule